// File: doc/BRIEF.md
# Tagged Word Classifier and Converter

This unit works on 33-bit register values: a 32-bit word together with an extra out-of-band tag bit. That bit is held only in the register file and on the spill stack, never in memory. The unit reports which of four classes a value belongs to: raw data, SmallInteger, Character or object pointer. It also converts between SmallIntegers and raw words. A SmallInteger is turned into a plain 32-bit word. A raw word becomes a SmallInteger again only when it fits the 31-bit payload.

Pointers are protected in hardware. User-level code that asks the unit to alter an object pointer gets a trap request and an unchanged operand. The same happens for a conversion that does not fit or does not apply. A trap request asks the supervisor to perform the operation. In supervisor mode every operation is a plain pass-through and never traps.

Each request is presented with a valid strobe. The result is registered one cycle later, together with its class and a trap flag.

Top module: `tagword_unit`

## Requirements
- R1: Every cycle with `in_valid` high produces `out_valid` high on the following cycle only. When `in_valid` is low, `out_valid` falls on the next cycle while `out_tag`, `out_word`, `out_class` and `out_trap` keep their last values.
- R2: Classes are encoded as follows:
  - 00 raw: tag bit 0.
  - 01 SmallInteger: tag bit 1 and word bit 0 = 1; the payload is bits 31:1.
  - 10 Character: tag bit 1 and word bits 1:0 = 10.
  - 11 object pointer: tag bit 1 and word bits 1:0 = 00.
- R3: Operation code 00 (pass) returns all 33 bits unchanged and never traps. This keeps the tag bit intact when a value is spilled to and restored from the stack.
- R4: Operation code 01 (untag) works as follows:
  - On a SmallInteger it returns tag 0 and the word shifted right arithmetically by one.
  - On a raw value it returns the value unchanged without a trap.
  - On a Character or pointer it traps.
- R5: Operation code 10 (retag) works as follows:
  - On a raw word whose bits 31 and 30 are equal, it returns tag 1 and the word shifted left by one with bit 0 set.
  - On a raw word whose bits 31 and 30 differ, it raises an overflow trap.
  - On a SmallInteger it returns the value unchanged without a trap.
- R6: In user mode (`in_super` = 0), operation codes 01, 10 and 11 applied to an object pointer raise `out_trap`. Operation code 10 applied to a Character also traps.
- R7: Operation code 11 (raw cast) clears the tag bit and keeps the word for raw, SmallInteger and Character operands.
- R8: Whenever `out_trap` is 1, `out_tag` and `out_word` equal the operand that caused it.
- R9: In supervisor mode (`in_super` = 1) no operation traps, and every operation returns its operand bits unchanged.
- R10: `out_class` is the R2 class of the registered result (`out_tag`, `out_word`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_tag | input | 1 | Extra tag bit of the operand |
| in_word | input | 32 | Operand word |
| in_op | input | 2 | Operation: 00 pass, 01 untag, 10 retag, 11 raw cast |
| in_super | input | 1 | 1 = supervisor level, 0 = user level |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_tag | output | 1 | Extra tag bit of the result |
| out_word | output | 32 | Result word |
| out_class | output | 2 | Class of the result (R2 encoding) |
| out_trap | output | 1 | Trap request to the supervisor |

## Verification
The bench targets the edges of the 31-bit range:
- Raw words 0x3FFFFFFF and 0xC0000000 still fit. A fit test on the wrong bits would trap on them.
- Raw words 0x40000000 and 0x80000000 must overflow. A wrong fit test would wrap them into a wrong SmallInteger.

It untags negative SmallIntegers such as 0x80000001. A logical shift would give a large positive word instead of 0xC0000000.

It applies each modifying operation to an object pointer in user mode, then the same requests in supervisor mode. A leak in the protection shows up as a changed pointer or a missing trap. Wrong privilege gating shows up as a spurious trap in supervisor mode.

Idle cycles between requests expose outputs that fail to hold.

// File: rtl/tagword_pkg.sv
package tagword_pkg;

  typedef enum logic [1:0] {
    CLS_RAW      = 2'b00,
    CLS_SMALLINT = 2'b01,
    CLS_CHAR     = 2'b10,
    CLS_OBJPTR   = 2'b11
  } word_class_e;

  typedef enum logic [1:0] {
    OP_PASS    = 2'b00,
    OP_UNTAG   = 2'b01,
    OP_RETAG   = 2'b10,
    OP_RAWCAST = 2'b11
  } word_op_e;

endpackage

// File: rtl/tagword_rst_sync.sv
module tagword_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tagword_classify.sv
module tagword_classify
  import tagword_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         tag,
  input  logic [W-1:0] word,
  output word_class_e  cls
);

  always_comb begin
    if (!tag)         cls = CLS_RAW;
    else if (word[0]) cls = CLS_SMALLINT;
    else if (word[1]) cls = CLS_CHAR;
    else              cls = CLS_OBJPTR;
  end

endmodule

// File: rtl/tagword_convert.sv
module tagword_convert
  import tagword_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         op_tag,
  input  logic [W-1:0] op_word,
  input  word_class_e  op_cls,
  input  word_op_e     op,
  input  logic         super_mode,
  output logic         res_tag,
  output logic [W-1:0] res_word,
  output logic         res_trap
);

  localparam int PAYLOAD_W = W - 1;

  logic           fits_small;
  logic           conv_tag;
  logic [W-1:0]   conv_word;
  logic           conv_trap;

  // A raw word fits the SmallInteger payload when its two top bits agree.
  assign fits_small = (op_word[W-1] == op_word[W-2]);

  always_comb begin
    conv_tag  = op_tag;
    conv_word = op_word;
    conv_trap = 1'b0;
    unique case (op)
      OP_PASS: ;
      OP_UNTAG: begin
        if (op_cls == CLS_SMALLINT) begin
          conv_tag  = 1'b0;
          conv_word = {op_word[W-1], op_word[W-1:1]};
        end else if (op_cls != CLS_RAW) begin
          conv_trap = 1'b1;
        end
      end
      OP_RETAG: begin
        if (op_cls == CLS_RAW) begin
          if (fits_small) begin
            conv_tag  = 1'b1;
            conv_word = {op_word[PAYLOAD_W-1:0], 1'b1};
          end else begin
            conv_trap = 1'b1;
          end
        end else if (op_cls != CLS_SMALLINT) begin
          conv_trap = 1'b1;
        end
      end
      OP_RAWCAST: begin
        if (op_cls == CLS_OBJPTR) conv_trap = 1'b1;
        else                      conv_tag  = 1'b0;
      end
      default: ;
    endcase
  end

  // Supervisor level and trapped requests leave the operand untouched.
  always_comb begin
    if (super_mode || conv_trap) begin
      res_tag  = op_tag;
      res_word = op_word;
    end else begin
      res_tag  = conv_tag;
      res_word = conv_word;
    end
    res_trap = conv_trap && !super_mode;
  end

endmodule

// File: rtl/tagword_outreg.sv
module tagword_outreg
  import tagword_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         nxt_tag,
  input  logic [W-1:0] nxt_word,
  input  word_class_e  nxt_cls,
  input  logic         nxt_trap,
  output logic         q_valid,
  output logic         q_tag,
  output logic [W-1:0] q_word,
  output word_class_e  q_cls,
  output logic         q_trap
);

  logic         valid_d;
  logic         tag_d;
  logic [W-1:0] word_d;
  word_class_e  cls_d;
  logic         trap_d;

  always_comb begin
    valid_d = load;
    tag_d   = q_tag;
    word_d  = q_word;
    cls_d   = q_cls;
    trap_d  = q_trap;
    if (load) begin
      tag_d  = nxt_tag;
      word_d = nxt_word;
      cls_d  = nxt_cls;
      trap_d = nxt_trap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_tag   <= 1'b0;
      q_word  <= '0;
      q_cls   <= CLS_RAW;
      q_trap  <= 1'b0;
    end else begin
      q_valid <= valid_d;
      q_tag   <= tag_d;
      q_word  <= word_d;
      q_cls   <= cls_d;
      q_trap  <= trap_d;
    end
  end

  // R1: strobe reaches the output one cycle later
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);

  // R1: no strobe, no valid, and held data
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (!q_valid && $stable(q_word) && $stable(q_tag) && $stable(q_trap)));

endmodule

// File: rtl/tagword_unit.sv
module tagword_unit
  import tagword_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_tag,
  input  logic [W-1:0] in_word,
  input  logic [1:0]   in_op,
  input  logic         in_super,
  output logic         out_valid,
  output logic         out_tag,
  output logic [W-1:0] out_word,
  output logic [1:0]   out_class,
  output logic         out_trap
);

  logic         rst_sync_n;
  word_class_e  cls_in;
  word_class_e  cls_res;
  word_class_e  cls_q;
  word_op_e     op_sel;
  logic         res_tag;
  logic [W-1:0] res_word;
  logic         res_trap;

  assign op_sel = word_op_e'(in_op);

  tagword_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tagword_classify #(.W(W)) i_cls_in (
    .tag  (in_tag),
    .word (in_word),
    .cls  (cls_in)
  );

  tagword_convert #(.W(W)) i_convert (
    .op_tag     (in_tag),
    .op_word    (in_word),
    .op_cls     (cls_in),
    .op         (op_sel),
    .super_mode (in_super),
    .res_tag    (res_tag),
    .res_word   (res_word),
    .res_trap   (res_trap)
  );

  tagword_classify #(.W(W)) i_cls_res (
    .tag  (res_tag),
    .word (res_word),
    .cls  (cls_res)
  );

  tagword_outreg #(.W(W)) i_outreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (in_valid),
    .nxt_tag  (res_tag),
    .nxt_word (res_word),
    .nxt_cls  (cls_res),
    .nxt_trap (res_trap),
    .q_valid  (out_valid),
    .q_tag    (out_tag),
    .q_word   (out_word),
    .q_cls    (cls_q),
    .q_trap   (out_trap)
  );

  assign out_class = cls_q;

  // R6: user code may not alter a pointer
  a_r6_pointer_guard: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_super && cls_in == CLS_OBJPTR && op_sel != OP_PASS) |=> out_trap);

  // R5: out-of-range retag traps
  a_r5_retag_overflow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_super && op_sel == OP_RETAG && !in_tag
     && (in_word[W-1] != in_word[W-2])) |=> out_trap);

  // R9: supervisor requests pass through untouched
  a_r9_super_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_super) |=> (!out_trap && out_tag == $past(in_tag)
                                && out_word == $past(in_word)));

  // R8: a trapped request leaves the operand in place
  a_r8_trap_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (!out_trap || (out_tag == $past(in_tag) && out_word == $past(in_word))));

  // R3: pass keeps all 33 bits
  a_r3_pass_exact: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op_sel == OP_PASS) |=> (!out_trap && out_tag == $past(in_tag)
                                         && out_word == $past(in_word)));

  // R10: a tagged result with low bits 00 is reported as a pointer
  a_r10_ptr_class: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_tag && out_word[1:0] == 2'b00) |-> out_class == 2'b11);

endmodule

// File: tb/test_tagword_unit.sv
`timescale 1ns/1ps
module test_tagword_unit;

  typedef struct {
    logic        tag;
    logic [31:0] word;
    logic [1:0]  cls;
    logic        trap;
    string       req;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_tag;
  logic [31:0] in_word;
  logic [1:0]  in_op;
  logic        in_super;
  logic        out_valid;
  logic        out_tag;
  logic [31:0] out_word;
  logic [1:0]  out_class;
  logic        out_trap;

  int checks_total;
  int checks_failed;
  bit finished;
  exp_t sb_q[$];
  logic [31:0] last_word;

  tagword_unit i_tagword_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .in_word   (in_word),
    .in_op     (in_op),
    .in_super  (in_super),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_word  (out_word),
    .out_class (out_class),
    .out_trap  (out_trap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Requirement-level reference: class encoding R2
  function automatic logic [1:0] ref_class(logic t, logic [31:0] w);
    if (!t)        return 2'b00;
    else if (w[0]) return 2'b01;
    else if (w[1]) return 2'b10;
    else           return 2'b11;
  endfunction

  // Returns {trap, tag, word} per R3..R9
  function automatic logic [33:0] ref_result(logic t, logic [31:0] w,
                                              logic [1:0] op, logic sup);
    logic [1:0] c;
    c = ref_class(t, w);
    if (sup) return {1'b0, t, w};
    case (op)
      2'b01: begin
        if (c == 2'b01) return {1'b0, 1'b0, 32'($signed(w) >>> 1)};
        if (c == 2'b00) return {1'b0, t, w};
        return {1'b1, t, w};
      end
      2'b10: begin
        if (c == 2'b00) begin
          if ($signed(w) >= -32'sd1073741824 && $signed(w) <= 32'sd1073741823)
            return {1'b0, 1'b1, w[30:0], 1'b1};
          return {1'b1, t, w};
        end
        if (c == 2'b01) return {1'b0, t, w};
        return {1'b1, t, w};
      end
      2'b11: begin
        if (c == 2'b11) return {1'b1, t, w};
        return {1'b0, 1'b0, w};
      end
      default: return {1'b0, t, w};
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks_total++;
    if (!ok) begin
      checks_failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic t, logic [31:0] w, logic [1:0] op, logic sup, string req);
    logic [33:0] r;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_tag   = t;
    in_word  = w;
    in_op    = op;
    in_super = sup;
    r = ref_result(t, w, op, sup);
    e.trap = r[33];
    e.tag  = r[32];
    e.word = r[31:0];
    e.cls  = ref_class(r[32], r[31:0]);
    e.req  = req;
    last_word = r[31:0];
    sb_q.push_back(e);
  endtask

  task automatic idle_hold_check();
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'hDEAD_BEEF;
    in_tag   = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after idle", 64'(out_valid), 64'd0);
    check(out_word == last_word, "R1", "word held when idle", 64'(out_word), 64'(last_word));
  endtask

  // Monitor: compare each registered result against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R1", "unexpected out_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(out_trap == e.trap, e.req, "trap", 64'(out_trap), 64'(e.trap));
          check(out_tag == e.tag && out_word == e.word, e.req, "result",
                {31'd0, out_tag, out_word}, {31'd0, e.tag, e.word});
          check(out_class == e.cls, {e.req, "/R10"}, "class", 64'(out_class), 64'(e.cls));
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks_total++;
      checks_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
      $finish;
    end
  end

  initial begin
    checks_total = 0;
    checks_failed = 0;
    finished = 0;
    last_word = '0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_tag = 1'b0;
    in_word = '0;
    in_op = 2'b00;
    in_super = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && out_trap == 1'b0, "R1", "reset state",
          {62'd0, out_valid, out_trap}, 64'd0);

    // R2 / R3: pass on each class, including the spill path of the tag bit
    drive(1'b0, 32'h1234_5678, 2'b00, 1'b0, "R2/R3 raw");
    drive(1'b1, 32'h0000_00A5, 2'b00, 1'b0, "R2/R3 smallint");
    drive(1'b1, 32'h0000_0412, 2'b00, 1'b0, "R2/R3 char");
    drive(1'b1, 32'h0001_0000, 2'b00, 1'b0, "R2/R3 pointer");
    // R4: untag
    drive(1'b1, 32'h0000_00A5, 2'b01, 1'b0, "R4 untag positive");
    drive(1'b1, 32'hFFFF_FFFF, 2'b01, 1'b0, "R4 untag minus one");
    drive(1'b1, 32'h8000_0001, 2'b01, 1'b0, "R4 untag most negative");
    drive(1'b0, 32'h8765_4321, 2'b01, 1'b0, "R4 untag raw");
    drive(1'b1, 32'h0000_0412, 2'b01, 1'b0, "R4 untag char traps");
    idle_hold_check();
    // R5: retag at range edges
    drive(1'b0, 32'h0000_0005, 2'b10, 1'b0, "R5 retag small");
    drive(1'b0, 32'h3FFF_FFFF, 2'b10, 1'b0, "R5 retag max");
    drive(1'b0, 32'hC000_0000, 2'b10, 1'b0, "R5 retag min");
    drive(1'b0, 32'h4000_0000, 2'b10, 1'b0, "R5 overflow positive");
    drive(1'b0, 32'h8000_0000, 2'b10, 1'b0, "R5 overflow negative");
    drive(1'b1, 32'h0000_0007, 2'b10, 1'b0, "R5 retag smallint");
    // R6 / R8: pointer protection in user mode
    drive(1'b1, 32'h0002_0000, 2'b01, 1'b0, "R6/R8 untag pointer");
    drive(1'b1, 32'h0002_0000, 2'b10, 1'b0, "R6/R8 retag pointer");
    drive(1'b1, 32'h0002_0000, 2'b11, 1'b0, "R6/R8 rawcast pointer");
    drive(1'b1, 32'h0000_0412, 2'b10, 1'b0, "R6 retag char");
    // R7: raw cast
    drive(1'b1, 32'h0000_00A5, 2'b11, 1'b0, "R7 rawcast smallint");
    drive(1'b1, 32'h0000_0412, 2'b11, 1'b0, "R7 rawcast char");
    drive(1'b0, 32'hCAFE_0000, 2'b11, 1'b0, "R7 rawcast raw");
    idle_hold_check();
    // R9: supervisor level
    drive(1'b1, 32'h0002_0000, 2'b01, 1'b1, "R9 super untag pointer");
    drive(1'b1, 32'h0002_0000, 2'b11, 1'b1, "R9 super rawcast pointer");
    drive(1'b0, 32'h4000_0000, 2'b10, 1'b1, "R9 super overflow");
    drive(1'b1, 32'h0000_00A5, 2'b01, 1'b1, "R9 super untag smallint");
    idle_hold_check();
    check(sb_q.size() == 0, "R1", "all results seen", 64'(sb_q.size()), 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
    $finish;
  end

endmodule